// File: doc/BRIEF.md
# Energy-Aware Route Request Responder

This block holds the per-node decision logic of a battery-gated route discovery scheme. As a relay, it checks each incoming route request against an acceptance threshold held in percent of full charge. It then accepts the request, which means forwarding it, or refuses it, which means sending a drop notice. The threshold starts high. It steps down when a request comes back with a larger sequence number than any the node has already seen. A node therefore only volunteers when it is well charged, and it relaxes its standards only when the route search keeps failing.

Drop notices heard from other nodes tell this node about a sequence number that is already being refused. The next request above that number then lowers the threshold here as well. This stops every node along a path from forcing its own round of re-sends. As an originator, the block waits a fixed number of cycles for a matching reply and keeps the first one. When no reply arrives in time, it asks for a re-send with the sequence number incremented.

Top module: `energy_route_node`

## Requirements
- R1: After reset every command output is low and the acceptance threshold is INIT_PCT (default 90). A request with battery 90 is refused and one with battery 91 is accepted.
- R2: A request is accepted when battery_i is strictly greater than the effective threshold. accept_o pulses for one cycle, in the cycle after the request, and cmd_seq_o carries the request's sequence number.
- R3: A request does not lower the threshold in two cases: the node knows no sequence number yet (first request after reset), or the request's sequence number is less than or equal to the largest one known.
- R4: A request whose sequence number is greater than the largest known lowers the threshold by one step, and the request is evaluated against the lowered value. A repeat of that same sequence number does not lower it again.
- R5: A refused request makes drop_o pulse for one cycle, in the cycle after the request, with cmd_seq_o equal to the request's sequence number. accept_o and drop_o are never high together.
- R6: An incoming drop notice whose number is above the largest known becomes the new largest known. It does not change the threshold and drives no output. A drop notice given in the same cycle as a request is ignored.
- R7: The threshold saturates at 0. With threshold 0, battery 1 is accepted and battery 0 is refused.
- R8: The step size is STEP_PCT clamped into the range 10 to 40. A setting of 60 behaves as 40.
- R9: While waiting, the first reply whose sequence number equals the current one pulses sel_valid_o with its id. The block ignores replies with any other number, and it ignores all replies once one has been selected, until the next start.
- R10: If no matching reply arrives within TIMEOUT cycles of a start or of a re-send, rtx_o pulses once with rtx_seq_o equal to the current number plus 1 (modulo 2^SEQ_W), and the wait restarts with that number.
- R11: send_start_i restarts the wait from any state. A matching reply that arrives in the timeout cycle wins, so no re-send is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| battery_i | input | 8 | Battery level, percent |
| req_valid_i | input | 1 | Route request received |
| req_seq_i | input | SEQ_W | Sequence number of the request |
| dropn_valid_i | input | 1 | Drop notice received |
| dropn_seq_i | input | SEQ_W | Sequence number of the drop notice |
| accept_o | output | 1 | Accept and forward command |
| drop_o | output | 1 | Emit-drop-notice command |
| cmd_seq_o | output | SEQ_W | Sequence number for accept or drop |
| send_start_i | input | 1 | Begin route discovery as originator |
| send_seq_i | input | SEQ_W | Initial sequence number |
| reply_valid_i | input | 1 | Reply received |
| reply_seq_i | input | SEQ_W | Sequence number of the reply |
| reply_id_i | input | ID_W | Id of the replying node |
| sel_valid_o | output | 1 | First reply selected |
| sel_id_o | output | ID_W | Id of the selected replier |
| rtx_o | output | 1 | Re-send request command |
| rtx_seq_o | output | SEQ_W | Sequence number for the re-send |

## Verification
The hardest cases to reach from the ports involve timing and history. One is a reply that lands in exactly the cycle the timeout expires. Another is a drop notice that coincides with a request. A third is a threshold worn down to zero by repeated sequence increases. The stimulus counts negedges from the start to place the reply on the expiry edge. It drives both relay events in one cycle, and the request that follows then shows whether the notice was recorded. A chain of increasing sequence numbers drives the threshold down to zero, and batteries of 1 and 0 then probe it.

// File: rtl/lear_pkg.sv
package lear_pkg;
    typedef logic [7:0] pct_t;

    localparam int STEP_MIN = 10;
    localparam int STEP_MAX = 40;

    typedef enum logic [1:0] {
        SND_IDLE = 2'd0,
        SND_WAIT = 2'd1,
        SND_DONE = 2'd2
    } snd_state_e;

    typedef struct packed {
        logic accept;
        logic refuse;
    } verdict_t;

    function automatic pct_t pct_sat_sub(pct_t a, pct_t b);
        return (a > b) ? pct_t'(a - b) : pct_t'(0);
    endfunction

    function automatic int clamp_step(int s);
        if (s < STEP_MIN) return STEP_MIN;
        if (s > STEP_MAX) return STEP_MAX;
        return s;
    endfunction
endpackage

// File: rtl/relay_threshold.sv
module relay_threshold
    import lear_pkg::*;
#(
    parameter int SEQ_W    = 8,
    parameter int INIT_PCT = 90,
    parameter int STEP_PCT = 25
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [SEQ_W-1:0] req_seq,
    input  logic             drop_valid,
    input  logic [SEQ_W-1:0] drop_seq,
    output pct_t             thr_eff
);
    localparam int   STEP     = clamp_step(STEP_PCT);
    localparam pct_t STEP_P   = pct_t'(STEP);
    localparam pct_t INIT_P   = pct_t'(INIT_PCT);

    pct_t             thr_q;
    logic [SEQ_W-1:0] last_q;
    logic             known_q;
    logic             req_newer;
    logic             drop_newer;

    always_comb begin
        req_newer  = !known_q || (req_seq > last_q);
        drop_newer = !known_q || (drop_seq > last_q);
        thr_eff    = (req_valid && known_q && (req_seq > last_q))
                     ? pct_sat_sub(thr_q, STEP_P) : thr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q   <= INIT_P;
            last_q  <= '0;
            known_q <= 1'b0;
        end else if (req_valid) begin
            thr_q <= thr_eff;
            if (req_newer) begin
                last_q  <= req_seq;
                known_q <= 1'b1;
            end
        end else if (drop_valid && drop_newer) begin
            last_q  <= drop_seq;
            known_q <= 1'b1;
        end
    end

    p_thr_monotone_r4: assert property (@(posedge clk) disable iff (rst)
        thr_q <= $past(thr_q));
    p_thr_bound_r1: assert property (@(posedge clk) disable iff (rst)
        thr_q <= INIT_P);
    p_drop_keeps_thr_r6: assert property (@(posedge clk) disable iff (rst)
        (!req_valid) |=> (thr_q == $past(thr_q)));
endmodule

// File: rtl/relay_decider.sv
module relay_decider
    import lear_pkg::*;
#(
    parameter int SEQ_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [SEQ_W-1:0] req_seq,
    input  pct_t             battery,
    input  pct_t             thr_eff,
    output logic             accept_o,
    output logic             drop_o,
    output logic [SEQ_W-1:0] seq_o
);
    verdict_t         v_d, v_q;
    logic [SEQ_W-1:0] seq_q;

    always_comb begin
        v_d.accept = req_valid && (battery > thr_eff);
        v_d.refuse = req_valid && !(battery > thr_eff);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q   <= '0;
            seq_q <= '0;
        end else begin
            v_q <= v_d;
            if (req_valid) seq_q <= req_seq;
        end
    end

    assign accept_o = v_q.accept;
    assign drop_o   = v_q.refuse;
    assign seq_o    = seq_q;

    p_verdict_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(accept_o && drop_o));
    p_verdict_needs_req_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (accept_o || drop_o));
    p_verdict_seq_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (seq_o == $past(req_seq)));
endmodule

// File: rtl/reply_arbiter.sv
module reply_arbiter
    import lear_pkg::*;
#(
    parameter int SEQ_W   = 8,
    parameter int ID_W    = 8,
    parameter int TIMEOUT = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             send_start,
    input  logic [SEQ_W-1:0] send_seq,
    input  logic             reply_valid,
    input  logic [SEQ_W-1:0] reply_seq,
    input  logic [ID_W-1:0]  reply_id,
    output logic             sel_valid_o,
    output logic [ID_W-1:0]  sel_id_o,
    output logic             rtx_o,
    output logic [SEQ_W-1:0] rtx_seq_o
);
    localparam int              CNT_W   = $clog2(TIMEOUT + 1);
    localparam logic [CNT_W-1:0] TO_LAST = CNT_W'(TIMEOUT - 1);

    snd_state_e       state_q;
    logic [SEQ_W-1:0] seq_q;
    logic [CNT_W-1:0] cnt_q;
    logic             hit;
    logic             expire;

    always_comb begin
        hit    = (state_q == SND_WAIT) && reply_valid && (reply_seq == seq_q);
        expire = (state_q == SND_WAIT) && !hit && (cnt_q == TO_LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= SND_IDLE;
            seq_q       <= '0;
            cnt_q       <= '0;
            sel_valid_o <= 1'b0;
            sel_id_o    <= '0;
            rtx_o       <= 1'b0;
            rtx_seq_o   <= '0;
        end else begin
            sel_valid_o <= 1'b0;
            rtx_o       <= 1'b0;
            if (send_start) begin
                state_q <= SND_WAIT;
                seq_q   <= send_seq;
                cnt_q   <= '0;
            end else if (hit) begin
                state_q     <= SND_DONE;
                sel_valid_o <= 1'b1;
                sel_id_o    <= reply_id;
            end else if (expire) begin
                seq_q     <= seq_q + SEQ_W'(1);
                rtx_o     <= 1'b1;
                rtx_seq_o <= seq_q + SEQ_W'(1);
                cnt_q     <= '0;
            end else if (state_q == SND_WAIT) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    p_sel_single_r9: assert property (@(posedge clk) disable iff (rst)
        sel_valid_o |=> !sel_valid_o);
    p_done_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == SND_DONE && !send_start) |=> (!sel_valid_o && !rtx_o));
    p_sel_rtx_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(sel_valid_o && rtx_o));
    p_rtx_seq_step_r10: assert property (@(posedge clk) disable iff (rst)
        rtx_o |-> (rtx_seq_o == seq_q));
    p_cnt_bound_r10: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= TO_LAST);
endmodule

// File: rtl/energy_route_node.sv
module energy_route_node
    import lear_pkg::*;
#(
    parameter int SEQ_W    = 8,
    parameter int ID_W     = 8,
    parameter int INIT_PCT = 90,
    parameter int STEP_PCT = 25,
    parameter int TIMEOUT  = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       battery_i,
    input  logic             req_valid_i,
    input  logic [SEQ_W-1:0] req_seq_i,
    input  logic             dropn_valid_i,
    input  logic [SEQ_W-1:0] dropn_seq_i,
    output logic             accept_o,
    output logic             drop_o,
    output logic [SEQ_W-1:0] cmd_seq_o,
    input  logic             send_start_i,
    input  logic [SEQ_W-1:0] send_seq_i,
    input  logic             reply_valid_i,
    input  logic [SEQ_W-1:0] reply_seq_i,
    input  logic [ID_W-1:0]  reply_id_i,
    output logic             sel_valid_o,
    output logic [ID_W-1:0]  sel_id_o,
    output logic             rtx_o,
    output logic [SEQ_W-1:0] rtx_seq_o
);
    pct_t thr_eff;

    relay_threshold #(
        .SEQ_W(SEQ_W), .INIT_PCT(INIT_PCT), .STEP_PCT(STEP_PCT)
    ) u_thr (
        .clk(clk), .rst(rst),
        .req_valid(req_valid_i), .req_seq(req_seq_i),
        .drop_valid(dropn_valid_i), .drop_seq(dropn_seq_i),
        .thr_eff(thr_eff)
    );

    relay_decider #(.SEQ_W(SEQ_W)) u_dec (
        .clk(clk), .rst(rst),
        .req_valid(req_valid_i), .req_seq(req_seq_i),
        .battery(battery_i), .thr_eff(thr_eff),
        .accept_o(accept_o), .drop_o(drop_o), .seq_o(cmd_seq_o)
    );

    reply_arbiter #(
        .SEQ_W(SEQ_W), .ID_W(ID_W), .TIMEOUT(TIMEOUT)
    ) u_arb (
        .clk(clk), .rst(rst),
        .send_start(send_start_i), .send_seq(send_seq_i),
        .reply_valid(reply_valid_i), .reply_seq(reply_seq_i), .reply_id(reply_id_i),
        .sel_valid_o(sel_valid_o), .sel_id_o(sel_id_o),
        .rtx_o(rtx_o), .rtx_seq_o(rtx_seq_o)
    );
endmodule

// File: tb/tb_energy_route_node.sv
module tb_energy_route_node;
    localparam int TO = 16;
    localparam int STEP = 25;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [7:0] battery = '0, req_seq = '0, dn_seq = '0, s_seq = '0, r_seq = '0, r_id = '0;
    logic req_v = 0, dn_v = 0, s_start = 0, r_v = 0;
    logic acc, drp, sel, rtx;
    logic [7:0] cseq, sid, rseq;

    energy_route_node #(.TIMEOUT(TO), .STEP_PCT(STEP)) dut (
        .clk(clk), .rst(rst), .battery_i(battery),
        .req_valid_i(req_v), .req_seq_i(req_seq),
        .dropn_valid_i(dn_v), .dropn_seq_i(dn_seq),
        .accept_o(acc), .drop_o(drp), .cmd_seq_o(cseq),
        .send_start_i(s_start), .send_seq_i(s_seq),
        .reply_valid_i(r_v), .reply_seq_i(r_seq), .reply_id_i(r_id),
        .sel_valid_o(sel), .sel_id_o(sid), .rtx_o(rtx), .rtx_seq_o(rseq));

    // second instance: oversized step setting
    logic [7:0] b2 = '0, q2 = '0;
    logic v2 = 0;
    logic acc2, drp2, sel2, rtx2;
    logic [7:0] cseq2, sid2, rseq2;
    energy_route_node #(.STEP_PCT(60)) dut2 (
        .clk(clk), .rst(rst), .battery_i(b2),
        .req_valid_i(v2), .req_seq_i(q2),
        .dropn_valid_i(1'b0), .dropn_seq_i(8'd0),
        .accept_o(acc2), .drop_o(drp2), .cmd_seq_o(cseq2),
        .send_start_i(1'b0), .send_seq_i(8'd0),
        .reply_valid_i(1'b0), .reply_seq_i(8'd0), .reply_id_i(8'd0),
        .sel_valid_o(sel2), .sel_id_o(sid2), .rtx_o(rtx2), .rtx_seq_o(rseq2));

    int checks = 0, errors = 0;

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int m_thr, m_last, m_cnt, m_st;
    bit m_known;
    logic [7:0] m_sseq;
    int e_acc, e_drop, e_seq, e_sel, e_id, e_rtx, e_rseq;

    always @(posedge clk) begin
        if (rst) begin
            m_thr = 90; m_last = 0; m_known = 0; m_st = 0; m_sseq = 0; m_cnt = 0;
            e_acc = 0; e_drop = 0; e_seq = 0; e_sel = 0; e_id = 0; e_rtx = 0; e_rseq = 0;
        end else begin
            e_acc = 0; e_drop = 0;
            if (req_v) begin
                if (m_known && req_seq > m_last) m_thr = (m_thr > STEP) ? m_thr - STEP : 0;
                if (battery > m_thr) e_acc = 1; else e_drop = 1;
                e_seq = req_seq;
                if (!m_known || req_seq > m_last) begin m_last = req_seq; m_known = 1; end
            end else if (dn_v && (!m_known || dn_seq > m_last)) begin
                m_last = dn_seq; m_known = 1;
            end
            e_sel = 0; e_rtx = 0;
            if (s_start) begin
                m_st = 1; m_sseq = s_seq; m_cnt = 0;
            end else if (m_st == 1) begin
                if (r_v && r_seq == m_sseq) begin
                    e_sel = 1; e_id = r_id; m_st = 2;
                end else if (m_cnt == TO - 1) begin
                    m_sseq = m_sseq + 8'd1; e_rtx = 1; e_rseq = m_sseq; m_cnt = 0;
                end else m_cnt++;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            check("R2 model accept", acc, e_acc);
            check("R5 model drop", drp, e_drop);
            if (acc || drp) check("R2 model cmd_seq", cseq, e_seq);
            check("R9 model sel", sel, e_sel);
            if (sel) check("R9 model sel_id", sid, e_id);
            check("R10 model rtx", rtx, e_rtx);
            if (rtx) check("R10 model rtx_seq", rseq, e_rseq);
        end
    end

    task automatic req(input int b, input int s, input int ea, input int ed, string tag);
        @(negedge clk); battery = 8'(b); req_seq = 8'(s); req_v = 1;
        @(negedge clk); req_v = 0;
        check({tag, " accept"}, acc, ea);
        check({tag, " drop"}, drp, ed);
        check({tag, " seq"}, cseq, s);
    endtask

    task automatic req2(input int b, input int s, input int ea, string tag);
        @(negedge clk); b2 = 8'(b); q2 = 8'(s); v2 = 1;
        @(negedge clk); v2 = 0;
        check({tag, " accept"}, acc2, ea);
        check({tag, " drop"}, drp2, 1 - ea);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 reset accept", acc, 0);
        check("R1 reset drop", drp, 0);
        check("R1 reset sel", sel, 0);
        check("R1 reset rtx", rtx, 0);

        // relay side, INIT 90, STEP 25
        req(90, 5, 0, 1, "R1 R3 first req at 90");
        req(91, 5, 1, 0, "R1 R3 same seq at 91");
        req(66, 6, 1, 0, "R4 lowered to 65");
        req(65, 6, 0, 1, "R4 R5 no second lowering");
        req(65, 3, 0, 1, "R3 older seq");
        @(negedge clk); dn_seq = 9; dn_v = 1;
        @(negedge clk); dn_v = 0;
        check("R6 drop notice silent acc", acc, 0);
        check("R6 drop notice silent drop", drp, 0);
        req(65, 9, 0, 1, "R6 notice seq recorded, no lowering");
        req(41, 10, 1, 0, "R6 R4 lowered to 40");
        @(negedge clk); battery = 41; req_seq = 10; req_v = 1; dn_seq = 20; dn_v = 1;
        @(negedge clk); req_v = 0; dn_v = 0;
        check("R6 simultaneous accept", acc, 1);
        req(16, 11, 1, 0, "R6 coincident notice ignored");
        req(1, 12, 1, 0, "R7 saturated to 0");
        req(0, 13, 0, 1, "R7 zero battery refused");
        req(1, 13, 1, 0, "R7 stays at 0");

        // R8: step 60 acts as 40
        req2(50, 1, 0, "R8 first");
        req2(51, 2, 1, "R8 lowered to 50");
        req2(10, 3, 0, "R8 lowered to 10");

        // sender: timeout and re-send
        @(negedge clk); s_seq = 40; s_start = 1;
        @(negedge clk); s_start = 0;
        begin
            int k = 0;
            while (!rtx && k < 100) begin @(negedge clk); k++; end
            check("R10 timeout cycles", k, TO);
            check("R10 rtx seq", rseq, 41);
        end
        @(negedge clk); r_seq = 40; r_id = 3; r_v = 1;
        @(negedge clk); r_v = 0;
        check("R9 stale reply ignored", sel, 0);
        @(negedge clk); r_seq = 41; r_id = 7; r_v = 1;
        @(negedge clk); r_v = 0;
        check("R9 first reply sel", sel, 1);
        check("R9 first reply id", sid, 7);
        @(negedge clk); r_seq = 41; r_id = 9; r_v = 1;
        @(negedge clk); r_v = 0;
        check("R9 later reply ignored", sel, 0);
        repeat (2 * TO) @(negedge clk);
        check("R9 no rtx after select", rtx, 0);

        // R11: reply on the expiry edge wins
        @(negedge clk); s_seq = 100; s_start = 1;
        @(negedge clk); s_start = 0;
        repeat (TO - 1) @(negedge clk);
        r_seq = 100; r_id = 55; r_v = 1;
        @(negedge clk); r_v = 0;
        check("R11 reply at expiry sel", sel, 1);
        check("R11 reply at expiry rtx", rtx, 0);

        // R11: restart during wait
        @(negedge clk); s_seq = 200; s_start = 1;
        @(negedge clk); s_start = 0;
        repeat (10) @(negedge clk);
        s_seq = 210; s_start = 1;
        @(negedge clk); s_start = 0;
        begin
            int k = 0;
            while (!rtx && k < 100) begin @(negedge clk); k++; end
            check("R11 restart timeout cycles", k, TO);
            check("R11 restart rtx seq", rseq, 211);
        end

        // wrap of the sequence number
        @(negedge clk); s_seq = 255; s_start = 1;
        @(negedge clk); s_start = 0;
        repeat (TO) @(negedge clk);
        check("R10 wrap rtx", rtx, 1);
        check("R10 wrap rtx seq", rseq, 0);
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule